// File: doc/BRIEF.md
# Per-Flow Packet Chain Reorder Tracker

This block keeps packets in arrival order within each flow while a pool of processing engines finishes them in any order. When a packet arrives, a dispatch request carrying its flow identifier is granted a free buffer block. That block is linked to the end of a chain kept for the flow. When an engine finishes a packet, it reports the block index on the completion port, which marks the block as processed. Each cycle a transmit stage picks one flow whose oldest outstanding block is processed. It emits that block, moves the flow's head to the next link and returns the block to the free pool.

The state sits in three places. A flow table holds, for each active flow, its identifier and the first and last block of its chain. A block table holds a link pointer, an in-use bit and a processed bit for each block. A free map hands out the lowest-numbered unused block. There is no global sequence number. Packets of different flows overtake each other freely, and only packets of the same flow are held back.

The defaults size the pool at 32 blocks, which suits 4 engines with 4 threads each plus room for reordering, and the flow table at 8 entries.

Top module: `flow_reorder_tracker`

## Requirements
- R1: After reset no block is transmitted, `done_err` is low, `disp_ready` is high and `disp_block` is 0.
- R2: While `disp_ready` is high, `disp_block` shows the lowest-numbered block not in use. A dispatch takes that block when `disp_valid` is high at the clock edge.
- R3: Blocks of one flow leave on `tx_block` in the order they were dispatched, whatever order they complete in, and `tx_flow` carries their flow identifier.
- R4: A block is transmitted only when it is the oldest outstanding block of its flow and has completed. It appears on `tx_valid`/`tx_block` in the cycle after the clock edge that accepted the completion of the last block it was waiting for.
- R5: A completed head block of one flow leaves even while another flow's older packet is still unprocessed.
- R6: At most one block leaves per cycle. Among flows with a ready head block, the flow table entries are served in rotating order, starting after the entry served last.
- R7: A transmitted block is back in the free pool after the clock edge that ends its transmit cycle, and not earlier.
- R8: `disp_ready` is low while all blocks are in use.
- R9: A dispatch for a flow identifier with no entry is refused (`disp_ready` low) while all flow entries are in use. A dispatch for a flow that has an entry is still accepted.
- R10: A completion for a block that is not in use, or that has already completed, raises `done_err` for one cycle, in the cycle after that edge, and changes no state. `done_err` is low otherwise.
- R11: When a flow's last outstanding block leaves, its entry is released for another flow. A dispatch to the same flow in that same cycle starts a new chain, with the new block as both first and last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request for a new packet |
| disp_flow | input | FID_W | Flow identifier of the new packet |
| disp_ready | output | 1 | A block and a flow entry are available for this request |
| disp_block | output | log2(NUM_BLOCKS) | Block index granted to the dispatch |
| done_valid | input | 1 | Completion report from a processing engine |
| done_block | input | log2(NUM_BLOCKS) | Block index being completed |
| done_err | output | 1 | Previous completion named an unused or already completed block |
| tx_valid | output | 1 | A block departs this cycle |
| tx_block | output | log2(NUM_BLOCKS) | Departing block index |
| tx_flow | output | FID_W | Flow identifier of the departing block |

## Verification
The dispatch grant is combinational and is read in the same cycle as the request. A completion is reflected on `tx_valid` and `done_err` one cycle after the edge that accepts it. A departing block becomes grantable again one edge after its transmit cycle. Each directed scenario drives inputs just after a rising edge and reads outputs at the following falling edge, in the cycle where each result falls due by this count. A background model keeps, for each flow, a queue of dispatched blocks and the set of blocks in use. It checks every grant and every departure against that model.

// File: rtl/frt_pkg.sv
package frt_pkg;
   localparam int DEF_BLOCKS = 32;
   localparam int DEF_FLOWS  = 8;
   localparam int DEF_FID_W  = 8;
endpackage

// File: rtl/frt_lowest_pick.sv
module frt_lowest_pick #(
   parameter int N = 8,
   localparam int W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0] req,
   output logic         found,
   output logic [W-1:0] idx
);
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            found = 1'b1;
            idx   = W'(i);
         end
      end
   end
endmodule

// File: rtl/frt_flow_cam.sv
module frt_flow_cam #(
   parameter int FLOWS = 8,
   parameter int FID_W = 8,
   localparam int FL_W = (FLOWS > 1) ? $clog2(FLOWS) : 1
) (
   input  logic [FLOWS-1:0]            ent_valid,
   input  logic [FLOWS-1:0][FID_W-1:0] ent_fid,
   input  logic [FID_W-1:0]            key,
   output logic                        hit,
   output logic [FL_W-1:0]             hit_idx,
   output logic                        empty_any,
   output logic [FL_W-1:0]             empty_idx
);
   logic [FLOWS-1:0] match;

   for (genvar i = 0; i < FLOWS; i++) begin : g_cmp
      assign match[i] = ent_valid[i] && (ent_fid[i] == key);
   end

   frt_lowest_pick #(.N(FLOWS)) u_hit (
      .req   (match),
      .found (hit),
      .idx   (hit_idx)
   );

   frt_lowest_pick #(.N(FLOWS)) u_empty (
      .req   (~ent_valid),
      .found (empty_any),
      .idx   (empty_idx)
   );
endmodule

// File: rtl/frt_tx_arb.sv
module frt_tx_arb #(
   parameter int FLOWS  = 8,
   parameter bit RR_ARB = 1'b1,
   localparam int FL_W = (FLOWS > 1) ? $clog2(FLOWS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [FLOWS-1:0] elig,
   output logic             gnt_v,
   output logic [FL_W-1:0]  gnt_idx
);
   if (RR_ARB) begin : g_rr
      logic [FL_W-1:0] ptr;
      int              j;

      always_comb begin
         gnt_v   = 1'b0;
         gnt_idx = '0;
         j       = 0;
         for (int k = FLOWS - 1; k >= 0; k--) begin
            j = int'(ptr) + k;
            if (j >= FLOWS) j = j - FLOWS;
            if (elig[j]) begin
               gnt_v   = 1'b1;
               gnt_idx = FL_W'(j);
            end
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ptr <= '0;
         end else if (gnt_v) begin
            ptr <= (gnt_idx == FL_W'(FLOWS - 1)) ? '0 : gnt_idx + 1'b1;
         end
      end
   end else begin : g_fixed
      frt_lowest_pick #(.N(FLOWS)) u_fix (
         .req   (elig),
         .found (gnt_v),
         .idx   (gnt_idx)
      );
   end
endmodule

// File: rtl/flow_reorder_tracker.sv
module flow_reorder_tracker #(
   parameter int NUM_BLOCKS = frt_pkg::DEF_BLOCKS,
   parameter int NUM_FLOWS  = frt_pkg::DEF_FLOWS,
   parameter int FID_W      = frt_pkg::DEF_FID_W,
   parameter bit RR_ARB     = 1'b1,
   localparam int BLK_W = $clog2(NUM_BLOCKS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             disp_valid,
   input  logic [FID_W-1:0] disp_flow,
   output logic             disp_ready,
   output logic [BLK_W-1:0] disp_block,
   input  logic             done_valid,
   input  logic [BLK_W-1:0] done_block,
   output logic             done_err,
   output logic             tx_valid,
   output logic [BLK_W-1:0] tx_block,
   output logic [FID_W-1:0] tx_flow
);
   localparam int FL_W = (NUM_FLOWS > 1) ? $clog2(NUM_FLOWS) : 1;

   if (NUM_BLOCKS < 2) begin : g_bad_blocks
      $error("NUM_BLOCKS must be at least 2");
   end
   if ((1 << BLK_W) != NUM_BLOCKS) begin : g_bad_pow2
      $error("NUM_BLOCKS must be a power of two");
   end
   if (NUM_FLOWS < 2) begin : g_bad_flows
      $error("NUM_FLOWS must be at least 2");
   end
   if (FID_W < 1) begin : g_bad_fid
      $error("FID_W must be at least 1");
   end

   // block table
   logic [NUM_BLOCKS-1:0]            blk_valid;
   logic [NUM_BLOCKS-1:0]            blk_done;
   logic [NUM_BLOCKS-1:0][BLK_W-1:0] blk_next;

   // flow table
   logic [NUM_FLOWS-1:0]             fl_valid;
   logic [NUM_FLOWS-1:0][FID_W-1:0]  fl_id;
   logic [NUM_FLOWS-1:0][BLK_W-1:0]  fl_head;
   logic [NUM_FLOWS-1:0][BLK_W-1:0]  fl_tail;

   logic             free_any;
   logic [BLK_W-1:0] free_idx;
   logic             hit, empty_any;
   logic [FL_W-1:0]  hit_idx, empty_idx;
   logic [NUM_FLOWS-1:0] elig;
   logic             gnt_v;
   logic [FL_W-1:0]  gnt_idx;
   logic             tx_last, disp_fire, done_bad, restart;

   frt_lowest_pick #(.N(NUM_BLOCKS)) u_free (
      .req   (~blk_valid),
      .found (free_any),
      .idx   (free_idx)
   );

   frt_flow_cam #(.FLOWS(NUM_FLOWS), .FID_W(FID_W)) u_cam (
      .ent_valid (fl_valid),
      .ent_fid   (fl_id),
      .key       (disp_flow),
      .hit       (hit),
      .hit_idx   (hit_idx),
      .empty_any (empty_any),
      .empty_idx (empty_idx)
   );

   for (genvar f = 0; f < NUM_FLOWS; f++) begin : g_elig
      assign elig[f] = fl_valid[f] && blk_done[fl_head[f]];
   end

   frt_tx_arb #(.FLOWS(NUM_FLOWS), .RR_ARB(RR_ARB)) u_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .elig    (elig),
      .gnt_v   (gnt_v),
      .gnt_idx (gnt_idx)
   );

   assign tx_valid   = gnt_v;
   assign tx_block   = fl_head[gnt_idx];
   assign tx_flow    = fl_id[gnt_idx];
   assign tx_last    = (fl_head[gnt_idx] == fl_tail[gnt_idx]);

   assign disp_ready = free_any && (hit || empty_any);
   assign disp_block = free_idx;
   assign disp_fire  = disp_valid && disp_ready;
   // the flow being appended to drains its only block this very cycle
   assign restart    = gnt_v && tx_last && hit && (gnt_idx == hit_idx);

   assign done_bad   = done_valid && (!blk_valid[done_block] || blk_done[done_block]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         blk_valid <= '0;
         blk_done  <= '0;
         blk_next  <= '0;
         done_err  <= 1'b0;
      end else begin
         done_err <= done_bad;
         if (gnt_v) begin
            blk_valid[tx_block] <= 1'b0;
            blk_done[tx_block]  <= 1'b0;
         end
         if (done_valid && !done_bad) begin
            blk_done[done_block] <= 1'b1;
         end
         if (disp_fire) begin
            blk_valid[free_idx] <= 1'b1;
            blk_done[free_idx]  <= 1'b0;
            if (hit && !restart) begin
               blk_next[fl_tail[hit_idx]] <= free_idx;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fl_valid <= '0;
         fl_id    <= '0;
         fl_head  <= '0;
         fl_tail  <= '0;
      end else begin
         if (gnt_v) begin
            if (tx_last) begin
               fl_valid[gnt_idx] <= 1'b0;
            end else begin
               fl_head[gnt_idx] <= blk_next[tx_block];
            end
         end
         if (disp_fire) begin
            if (hit) begin
               if (restart) begin
                  fl_valid[hit_idx] <= 1'b1;
                  fl_head[hit_idx]  <= free_idx;
               end
               fl_tail[hit_idx] <= free_idx;
            end else begin
               fl_valid[empty_idx] <= 1'b1;
               fl_id[empty_idx]    <= disp_flow;
               fl_head[empty_idx]  <= free_idx;
               fl_tail[empty_idx]  <= free_idx;
            end
         end
      end
   end
endmodule

// File: rtl/frt_checker.sv
module frt_checker #(
   parameter int NUM_BLOCKS = 32,
   localparam int BLK_W = $clog2(NUM_BLOCKS)
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  disp_valid,
   input logic                  disp_ready,
   input logic [BLK_W-1:0]      disp_block,
   input logic                  done_valid,
   input logic [BLK_W-1:0]      done_block,
   input logic                  done_err,
   input logic                  tx_valid,
   input logic [BLK_W-1:0]      tx_block,
   input logic [NUM_BLOCKS-1:0] blk_valid,
   input logic [NUM_BLOCKS-1:0] blk_done
);
   AST_TX_HEAD_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> (blk_valid[tx_block] && blk_done[tx_block])); // R4

   AST_DONE_IN_USE: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_done & ~blk_valid) == '0); // R4

   AST_GRANT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_valid && disp_ready) |-> !blk_valid[disp_block]); // R2

   AST_FREED_AFTER_TX: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |=> !blk_valid[$past(tx_block)]); // R7

   AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (&blk_valid) |-> !disp_ready); // R8

   AST_BAD_DONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (done_valid && (!blk_valid[done_block] || blk_done[done_block])) |=> done_err); // R10

   AST_NO_SPURIOUS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      !done_valid |=> !done_err); // R10
endmodule

bind flow_reorder_tracker frt_checker #(.NUM_BLOCKS(NUM_BLOCKS)) u_chk (.*);

// File: tb/flow_reorder_tracker_tb.sv
`timescale 1ns/1ps
module flow_reorder_tracker_tb;
   localparam int NB = 32;
   localparam int FW = 8;
   localparam int BW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          disp_valid = 1'b0;
   logic [FW-1:0] disp_flow = '0;
   logic          disp_ready;
   logic [BW-1:0] disp_block;
   logic          done_valid = 1'b0;
   logic [BW-1:0] done_block = '0;
   logic          done_err;
   logic          tx_valid;
   logic [BW-1:0] tx_block;
   logic [FW-1:0] tx_flow;

   flow_reorder_tracker u_dut (
      .clk(clk), .rst_n(rst_n),
      .disp_valid(disp_valid), .disp_flow(disp_flow),
      .disp_ready(disp_ready), .disp_block(disp_block),
      .done_valid(done_valid), .done_block(done_block), .done_err(done_err),
      .tx_valid(tx_valid), .tx_block(tx_block), .tx_flow(tx_flow)
   );

   always #2.5 clk = ~clk;

   int checks = 0;
   int errors = 0;

   // reference model
   bit busy [NB];
   bit dmod [NB];
   int mq [256][$];

   // samples of the last observed cycle
   bit s_tx_v, s_rdy, s_err;
   int s_tx_b, s_tx_f, s_blk;

   task automatic check(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int lowest_free();
      for (int i = 0; i < NB; i++) if (!busy[i]) return i;
      return -1;
   endfunction

   always @(negedge clk) begin
      if (rst_n) begin
         if (disp_valid && disp_ready) begin
            check("R2", "model grant", int'(disp_block), lowest_free());
            busy[disp_block] = 1'b1;
            mq[disp_flow].push_back(int'(disp_block));
         end
         if (done_valid && busy[done_block] && !dmod[done_block]) dmod[done_block] = 1'b1;
         if (tx_valid) begin
            if (mq[tx_flow].size() == 0) begin
               check("R3", "departure with nothing pending", int'(tx_block), -1);
            end else begin
               check("R3", "in-flow order", int'(tx_block), mq[tx_flow][0]);
               void'(mq[tx_flow].pop_front());
            end
            check("R4", "departing block completed", int'(dmod[tx_block]), 1);
            busy[tx_block] = 1'b0;
            dmod[tx_block] = 1'b0;
         end
      end
   end

   task automatic look();
      @(negedge clk);
      s_tx_v = tx_valid;  s_tx_b = int'(tx_block); s_tx_f = int'(tx_flow);
      s_rdy  = disp_ready; s_blk = int'(disp_block); s_err = done_err;
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic reset_dut();
      rst_n = 1'b0; disp_valid = 1'b0; done_valid = 1'b0;
      for (int i = 0; i < NB; i++) begin busy[i] = 1'b0; dmod[i] = 1'b0; end
      for (int f = 0; f < 256; f++) mq[f].delete();
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
   endtask

   task automatic dispatch(int fid);
      disp_valid = 1'b1; disp_flow = FW'(fid);
      look();
      step();
      disp_valid = 1'b0;
   endtask

   task automatic dispatch_chk(string req, int fid, int exp_blk);
      dispatch(fid);
      check(req, "ready on dispatch", int'(s_rdy), 1);
      check(req, "granted block", s_blk, exp_blk);
   endtask

   task automatic complete(int blk);
      done_valid = 1'b1; done_block = BW'(blk);
      look();
      step();
      done_valid = 1'b0;
   endtask

   task automatic expect_tx(string req, int v, int blk, int fid);
      look();
      check(req, "tx_valid", int'(s_tx_v), v);
      if (v != 0) begin
         check(req, "tx_block", s_tx_b, blk);
         check(req, "tx_flow", s_tx_f, fid);
      end
      step();
   endtask

   task automatic t_reset();
      reset_dut();
      look();
      check("R1", "tx_valid after reset", int'(s_tx_v), 0);
      check("R1", "ready after reset", int'(s_rdy), 1);
      check("R1", "first block after reset", s_blk, 0);
      check("R1", "error after reset", int'(s_err), 0);
      step();
   endtask

   task automatic t_order();
      reset_dut();
      dispatch_chk("R2", 5, 0);
      dispatch_chk("R2", 5, 1);
      dispatch_chk("R2", 5, 2);
      complete(2);
      complete(1);
      check("R4", "no departure while head pending", int'(s_tx_v), 0);
      complete(0);
      check("R4", "no departure before head completes", int'(s_tx_v), 0);
      expect_tx("R3", 1, 0, 5);
      expect_tx("R3", 1, 1, 5);
      expect_tx("R3", 1, 2, 5);
      expect_tx("R3", 0, 0, 0);
   endtask

   task automatic t_cross();
      reset_dut();
      dispatch_chk("R5", 1, 0);
      dispatch_chk("R5", 2, 1);
      complete(1);
      expect_tx("R5", 1, 1, 2);
      expect_tx("R5", 0, 0, 0);
      complete(0);
      expect_tx("R5", 1, 0, 1);
   endtask

   task automatic t_rr();
      reset_dut();
      dispatch_chk("R6", 3, 0);
      dispatch_chk("R6", 3, 1);
      dispatch_chk("R6", 4, 2);
      dispatch_chk("R6", 4, 3);
      complete(1);
      complete(3);
      complete(2);
      complete(0);
      check("R6", "first departure flow 4", s_tx_b, 2);
      expect_tx("R6", 1, 0, 3);
      expect_tx("R6", 1, 3, 4);
      expect_tx("R6", 1, 1, 3);
      expect_tx("R6", 0, 0, 0);
   endtask

   task automatic t_reuse();
      reset_dut();
      dispatch_chk("R7", 3, 0);
      dispatch_chk("R7", 3, 1);
      dispatch_chk("R7", 3, 2);
      complete(0);
      dispatch(4);
      check("R7", "departure seen", s_tx_b, 0);
      check("R7", "departing block not yet free", s_blk, 3);
      dispatch_chk("R7", 4, 0);
   endtask

   task automatic t_full();
      reset_dut();
      for (int i = 0; i < NB; i++) dispatch_chk("R2", i % 4, i);
      dispatch(0);
      check("R8", "ready with pool exhausted", int'(s_rdy), 0);
      complete(0);
      look();
      check("R8", "ready during departure cycle", int'(s_rdy), 0);
      check("R8", "departure of block 0", s_tx_b, 0);
      step();
      dispatch_chk("R8", 9, 0);
   endtask

   task automatic t_table();
      reset_dut();
      for (int i = 0; i < 8; i++) dispatch_chk("R9", 10 + i, i);
      dispatch(18);
      check("R9", "new flow refused when table full", int'(s_rdy), 0);
      dispatch_chk("R9", 10, 8);
   endtask

   task automatic t_err();
      reset_dut();
      complete(1);
      check("R10", "no error in completion cycle", int'(s_err), 0);
      look();
      check("R10", "error for unused block", int'(s_err), 1);
      step();
      look();
      check("R10", "error lasts one cycle", int'(s_err), 0);
      step();
      dispatch_chk("R10", 7, 0);
      dispatch_chk("R10", 8, 1);
      expect_tx("R10", 0, 0, 0);
      complete(1);
      complete(1);
      check("R10", "valid completion departs", s_tx_b, 1);
      look();
      check("R10", "error for repeated completion", int'(s_err), 1);
      check("R10", "flow 7 head still held", int'(tx_valid), 0);
      step();
   endtask

   task automatic t_restart();
      reset_dut();
      for (int i = 0; i < 7; i++) dispatch_chk("R11", 20 + i, i);
      dispatch_chk("R11", 6, 7);
      complete(7);
      dispatch(6);
      check("R11", "last block departs", s_tx_b, 7);
      check("R11", "same-cycle dispatch accepted", int'(s_rdy), 1);
      check("R11", "same-cycle dispatch block", s_blk, 8);
      expect_tx("R11", 0, 0, 0);
      complete(8);
      expect_tx("R11", 1, 8, 6);
      dispatch_chk("R11", 30, 7);
   endtask

   task automatic report();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      #(200000 * 5);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
   end

   initial begin
      t_reset();
      t_order();
      t_cross();
      t_rr();
      t_reuse();
      t_full();
      t_table();
      t_err();
      t_restart();
      repeat (4) step();
      report();
      $finish;
   end
endmodule